// File: doc/BRIEF.md
# E1 Digital Loss-of-Signal Monitor

This block watches one channel of a recovered E1 bit stream and decides when the signal has been lost and when it has returned. It sees one recovered data bit on each cycle where the bit-clock enable is high. A long run of zeros declares a digital loss. Returning from loss takes a period of sustained pulse density, measured over a sliding 32-bit window that also rejects long zero runs. The two decisions use separate rules, which gives hysteresis.

An external amplitude comparator supplies its own loss flag. The channel reports loss only when that analog flag and the digital decision agree. While the channel is in loss, an optional mute forces both recovered data rails to zero, so that noise is not passed downstream. An extended mode raises both the declare run and the clear period to 4096 bits.

Top module: `e1_los_monitor`

## Requirements
- R1: In normal mode (`ext_mode`=0), `dlos_out` rises on the clock edge that accepts the 32nd consecutive enabled zero bit. It does not rise after only 31 zeros.
- R2: In extended mode (`ext_mode`=1), `dlos_out` rises on the edge that accepts the 4096th consecutive zero bit. It does not rise after 4095 zeros.
- R3: A bit counts as qualifying when two things hold: the last 32 accepted bits, including the current one, hold at least 4 ones, and the current run of zeros is shorter than 16. In normal mode, a declared `dlos_out` falls on the edge that accepts the 32nd consecutive qualifying bit.
- R4: A bit with fewer than 4 ones in the window, or a zero that completes a run of 16 zeros, restarts the qualifying count from zero. A stream made of 4 ones followed by 16 zeros, repeated, never clears the loss. The same stream with 15 zeros in each gap does clear it.
- R5: In extended mode, a declared `dlos_out` falls only after 4096 consecutive qualifying bits.
- R6: `los_out` is high exactly when `dlos_out` is high and `alos_in` is high.
- R7: When `mute_en`=1 and `los_out`=1, `rdat_out` and `rneg_out` are both 0. Otherwise they equal `rx_bit` and `rx_neg`.
- R8: The zero-run count saturates and does not wrap. Any number of zeros, even more than 4096, keeps `dlos_out` high.
- R9: On cycles where `bit_en`=0, no state changes. `rx_bit` values on those cycles affect neither the declare count nor the clear count.
- R10: A synchronous reset (`rst`=1) sets `dlos_out` to 1, empties the window (all zeros) and zeroes both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable: one recovered bit is accepted per high cycle |
| rx_bit | input | 1 | Recovered data bit (positive rail or single-rail data) |
| rx_neg | input | 1 | Recovered negative-rail bit, passed through to `rneg_out` |
| ext_mode | input | 1 | 1 selects the 4096-bit declare and clear lengths |
| mute_en | input | 1 | 1 enables muting of both data outputs during channel loss |
| alos_in | input | 1 | Loss flag from the external amplitude comparator |
| dlos_out | output | 1 | Digital loss decision |
| los_out | output | 1 | Channel loss: digital AND analog |
| rdat_out | output | 1 | Recovered data, muted during loss when enabled |
| rneg_out | output | 1 | Recovered negative rail, muted during loss when enabled |

## Verification
The assertions check the following on every cycle. Muting holds during loss. The channel flag never rises without the analog flag. The window popcount matches the window contents. The zero-run counter stays within its saturation limit. A disabled cycle never moves the decision. Every fall of the decision is backed by a full qualifying count.

The exact edge on which loss is declared or cleared, in both modes, is shown only by the bench's bit sequences. The same holds for the contrast between 15-zero and 16-zero gaps, and for long zero stretches beyond the saturation point.

// File: rtl/e1_los_pkg.sv
package e1_los_pkg;
    typedef enum logic {
        LOS_MODE_NORMAL   = 1'b0,
        LOS_MODE_EXTENDED = 1'b1
    } los_mode_e;
endpackage

// File: rtl/e1_los_zero_run.sv
module e1_los_zero_run #(
    parameter int SAT = 4096,
    localparam int ZW = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          rx_bit,
    output logic [ZW-1:0] zrun_q,
    output logic [ZW-1:0] zrun_d
);
    localparam logic [ZW-1:0] SAT_V = ZW'(SAT);

    typedef struct packed {
        logic [ZW-1:0] cnt;
    } zr_state_t;

    zr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            if (rx_bit)
                st_d.cnt = '0;
            else if (st_q.cnt != SAT_V)
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign zrun_q = st_q.cnt;
    assign zrun_d = st_d.cnt;
endmodule

// File: rtl/e1_los_density.sv
module e1_los_density #(
    parameter int WIN_LEN = 32,
    localparam int CW = $clog2(WIN_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               rx_bit,
    output logic [WIN_LEN-1:0] win_q,
    output logic [CW-1:0]      ones_q,
    output logic [CW-1:0]      ones_d
);
    typedef struct packed {
        logic [WIN_LEN-1:0] win;
        logic [CW-1:0]      ones;
    } dn_state_t;

    dn_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            st_d.win  = {st_q.win[WIN_LEN-2:0], rx_bit};
            st_d.ones = st_q.ones + CW'(rx_bit) - CW'(st_q.win[WIN_LEN-1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign win_q  = st_q.win;
    assign ones_q = st_q.ones;
    assign ones_d = st_d.ones;
endmodule

// File: rtl/e1_los_qualify.sv
module e1_los_qualify
    import e1_los_pkg::*;
#(
    parameter int CLR_NORM = 32,
    parameter int CLR_EXT  = 4096,
    localparam int QSAT = (CLR_EXT > CLR_NORM) ? CLR_EXT : CLR_NORM,
    localparam int QW   = $clog2(QSAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          good,
    input  los_mode_e     mode,
    output logic [QW-1:0] qual_q,
    output logic          clr_ok
);
    localparam logic [QW-1:0] QSAT_V = QW'(QSAT);
    localparam logic [QW-1:0] NORM_V = QW'(CLR_NORM);
    localparam logic [QW-1:0] EXT_V  = QW'(CLR_EXT);

    typedef struct packed {
        logic [QW-1:0] cnt;
    } qu_state_t;

    qu_state_t     st_d, st_q;
    logic [QW-1:0] thr;

    always_comb begin
        st_d = st_q;
        thr  = (mode == LOS_MODE_EXTENDED) ? EXT_V : NORM_V;
        if (bit_en) begin
            if (!good)
                st_d.cnt = '0;
            else if (st_q.cnt != QSAT_V)
                st_d.cnt = st_q.cnt + 1'b1;
        end
        clr_ok = bit_en && (st_d.cnt >= thr);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign qual_q = st_q.cnt;
endmodule

// File: rtl/e1_los_monitor.sv
module e1_los_monitor
    import e1_los_pkg::*;
#(
    parameter int WIN_LEN   = 32,
    parameter int MIN_ONES  = 4,
    parameter int MAX_ZRUN  = 16,
    parameter int DECL_NORM = 32,
    parameter int DECL_EXT  = 4096,
    parameter int CLR_NORM  = 32,
    parameter int CLR_EXT   = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic rx_neg,
    input  logic ext_mode,
    input  logic mute_en,
    input  logic alos_in,
    output logic dlos_out,
    output logic los_out,
    output logic rdat_out,
    output logic rneg_out
);
    localparam int ZSAT = (DECL_EXT > DECL_NORM) ? DECL_EXT : DECL_NORM;
    localparam int ZW   = $clog2(ZSAT + 1);
    localparam int CW   = $clog2(WIN_LEN + 1);
    localparam int QSAT = (CLR_EXT > CLR_NORM) ? CLR_EXT : CLR_NORM;
    localparam int QW   = $clog2(QSAT + 1);

    localparam logic [ZW-1:0] DNORM_V = ZW'(DECL_NORM);
    localparam logic [ZW-1:0] DEXT_V  = ZW'(DECL_EXT);
    localparam logic [ZW-1:0] ZMAX_V  = ZW'(MAX_ZRUN);
    localparam logic [CW-1:0] ONES_V  = CW'(MIN_ONES);

    typedef struct packed {
        logic dlos;
    } top_state_t;

    top_state_t         st_d, st_q;
    los_mode_e          mode;
    logic [ZW-1:0]      zrun_q, zrun_d, decl_thr;
    logic [WIN_LEN-1:0] win_q;
    logic [CW-1:0]      ones_q, ones_d;
    logic [QW-1:0]      qual_q;
    logic               good, clr_ok, declare, mute_act;

    assign mode = ext_mode ? LOS_MODE_EXTENDED : LOS_MODE_NORMAL;

    e1_los_zero_run #(.SAT(ZSAT)) u_zrun (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .zrun_q(zrun_q), .zrun_d(zrun_d)
    );

    e1_los_density #(.WIN_LEN(WIN_LEN)) u_dens (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .win_q(win_q), .ones_q(ones_q), .ones_d(ones_d)
    );

    e1_los_qualify #(.CLR_NORM(CLR_NORM), .CLR_EXT(CLR_EXT)) u_qual (
        .clk(clk), .rst(rst), .bit_en(bit_en), .good(good), .mode(mode),
        .qual_q(qual_q), .clr_ok(clr_ok)
    );

    always_comb begin
        st_d     = st_q;
        decl_thr = (mode == LOS_MODE_EXTENDED) ? DEXT_V : DNORM_V;
        good     = (ones_d >= ONES_V) && (zrun_d < ZMAX_V);
        declare  = bit_en && (zrun_d >= decl_thr);
        if (!st_q.dlos && declare)
            st_d.dlos = 1'b1;
        else if (st_q.dlos && clr_ok)
            st_d.dlos = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{dlos: 1'b1};
        else     st_q <= st_d;
    end

    assign dlos_out = st_q.dlos;
    assign los_out  = st_q.dlos & alos_in;
    assign mute_act = mute_en & los_out;
    assign rdat_out = rx_bit & ~mute_act;
    assign rneg_out = rx_neg & ~mute_act;
endmodule

// File: rtl/e1_los_monitor_chk.sv
module e1_los_monitor_chk #(
    parameter int WIN_LEN   = 32,
    parameter int DECL_NORM = 32,
    parameter int DECL_EXT  = 4096,
    parameter int CLR_NORM  = 32,
    parameter int ZW        = 13,
    parameter int CW        = 6,
    parameter int QW        = 13
) (
    input logic               clk,
    input logic               rst,
    input logic               bit_en,
    input logic               rx_bit,
    input logic               ext_mode,
    input logic               mute_en,
    input logic               alos_in,
    input logic               dlos_out,
    input logic               los_out,
    input logic               rdat_out,
    input logic               rneg_out,
    input logic [ZW-1:0]      zrun,
    input logic [WIN_LEN-1:0] win,
    input logic [CW-1:0]      ones,
    input logic [QW-1:0]      qual
);
    localparam int ZSAT = (DECL_EXT > DECL_NORM) ? DECL_EXT : DECL_NORM;

    assert_declare_norm_R1: assert property (@(posedge clk) disable iff (rst)
        (!dlos_out && bit_en && !ext_mode && !rx_bit && zrun == ZW'(DECL_NORM - 1)) |=> dlos_out);

    assert_clear_backed_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(dlos_out) |-> (qual >= QW'(CLR_NORM)));

    assert_window_count_R4: assert property (@(posedge clk) disable iff (rst)
        ones == CW'($countones(win)));

    assert_and_analog_R6: assert property (@(posedge clk) disable iff (rst)
        los_out |-> (alos_in && dlos_out));

    assert_mute_R7: assert property (@(posedge clk) disable iff (rst)
        (mute_en && los_out) |-> (!rdat_out && !rneg_out));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        zrun <= ZW'(ZSAT));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(dlos_out));

    assert_rise_on_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(dlos_out) |-> $past(bit_en && !rx_bit));
endmodule

bind e1_los_monitor e1_los_monitor_chk #(
    .WIN_LEN(WIN_LEN), .DECL_NORM(DECL_NORM), .DECL_EXT(DECL_EXT),
    .CLR_NORM(CLR_NORM), .ZW(ZW), .CW(CW), .QW(QW)
) u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .ext_mode(ext_mode), .mute_en(mute_en), .alos_in(alos_in),
    .dlos_out(dlos_out), .los_out(los_out), .rdat_out(rdat_out),
    .rneg_out(rneg_out), .zrun(zrun_q), .win(win_q), .ones(ones_q),
    .qual(qual_q)
);

// File: tb/e1_los_monitor_tb.sv
module e1_los_monitor_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, rx_bit = 1'b0, rx_neg = 1'b0;
    logic ext_mode = 1'b0, mute_en = 1'b0, alos_in = 1'b0;
    logic dlos_out, los_out, rdat_out, rneg_out;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state, maintained from the requirements
    int m_zr = 0, m_qc = 0, m_ones = 0;
    bit m_dl = 1'b1;
    bit m_hist [32];

    always #2 clk = ~clk;

    e1_los_monitor u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .rx_neg(rx_neg),
        .ext_mode(ext_mode), .mute_en(mute_en), .alos_in(alos_in),
        .dlos_out(dlos_out), .los_out(los_out), .rdat_out(rdat_out), .rneg_out(rneg_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit b);
        int dthr, cthr;
        dthr = ext_mode ? 4096 : 32;
        cthr = ext_mode ? 4096 : 32;
        for (int i = 31; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = b;
        m_ones = 0;
        for (int i = 0; i < 32; i++) m_ones += m_hist[i];
        m_zr = b ? 0 : ((m_zr < 4096) ? m_zr + 1 : 4096);
        if (m_ones >= 4 && m_zr < 16) m_qc = (m_qc < 4096) ? m_qc + 1 : 4096;
        else m_qc = 0;
        if (!m_dl && m_zr >= dthr) m_dl = 1'b1;
        else if (m_dl && m_qc >= cthr) m_dl = 1'b0;
    endtask

    task automatic tick(input bit b, input bit en, input string tag);
        rx_bit = b;
        bit_en = en;
        @(posedge clk);
        #1;
        if (en) model_step(b);
        chk(dlos_out === m_dl, tag, dlos_out, m_dl);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_zr = 0; m_qc = 0; m_ones = 0; m_dl = 1'b1;
        for (int i = 0; i < 32; i++) m_hist[i] = 1'b0;
    endtask

    // one '1' every four bits: clears after exactly 44 bits from an empty window
    task automatic clear_by_pattern(input int nbits, input string tag);
        for (int i = 0; i < nbits; i++) tick((i % 4) == 0, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(dlos_out === 1'b1, "R10 reset dlos", dlos_out, 1);
        alos_in = 1'b1; #1;
        chk(los_out === 1'b1, "R10 reset los", los_out, 1);
        alos_in = 1'b0;

        // R3: 1000 pattern, qualifying from bit 13, clears on bit 44
        clear_by_pattern(43, "R3 pattern");
        chk(dlos_out === 1'b1, "R3 before 44th bit", dlos_out, 1);
        tick(1'b0, 1'b1, "R3 pattern");
        chk(dlos_out === 1'b0, "R3 cleared at 44th bit", dlos_out, 0);
        tick(1'b1, 1'b1, "R3 tail");

        // R1: 31 zeros keep clear, 32nd declares
        for (int i = 0; i < 31; i++) tick(1'b0, 1'b1, "R1 zeros");
        chk(dlos_out === 1'b0, "R1 after 31 zeros", dlos_out, 0);
        tick(1'b0, 1'b1, "R1 zero 32");
        chk(dlos_out === 1'b1, "R1 after 32 zeros", dlos_out, 1);

        // R4: 4 ones + 16 zeros never clears
        for (int r = 0; r < 12; r++)
            for (int i = 0; i < 20; i++) tick(i < 4, 1'b1, "R4 gap16");
        chk(dlos_out === 1'b1, "R4 gap16 stays declared", dlos_out, 1);
        // R4: 4 ones + 15 zeros clears
        for (int r = 0; r < 6; r++)
            for (int i = 0; i < 19; i++) tick(i < 4, 1'b1, "R4 gap15");
        chk(dlos_out === 1'b0, "R4 gap15 clears", dlos_out, 0);
        tick(1'b1, 1'b1, "R4 tail");

        // R9: disabled cycles with zeros change nothing
        for (int i = 0; i < 100; i++) tick(1'b0, 1'b0, "R9 frozen");
        chk(dlos_out === 1'b0, "R9 frozen stays clear", dlos_out, 0);
        for (int i = 0; i < 31; i++) tick(1'b0, 1'b1, "R9 zeros");
        chk(dlos_out === 1'b0, "R9 disabled zeros not counted", dlos_out, 0);
        tick(1'b0, 1'b1, "R9 zero 32");
        chk(dlos_out === 1'b1, "R9 declare after 32 enabled", dlos_out, 1);
        for (int i = 0; i < 60; i++) tick(i % 2, 1'b0, "R9 frozen ones");
        chk(dlos_out === 1'b1, "R9 disabled ones not counted", dlos_out, 1);

        // R2 / R5: extended mode
        do_reset();
        clear_by_pattern(44, "R3 prep");
        tick(1'b1, 1'b1, "R2 prep");
        ext_mode = 1'b1;
        for (int i = 0; i < 4095; i++) tick(1'b0, 1'b1, "R2 zeros");
        chk(dlos_out === 1'b0, "R2 after 4095 zeros", dlos_out, 0);
        tick(1'b0, 1'b1, "R2 zero 4096");
        chk(dlos_out === 1'b1, "R2 after 4096 zeros", dlos_out, 1);
        clear_by_pattern(4107, "R5 pattern");
        chk(dlos_out === 1'b1, "R5 before 4108th bit", dlos_out, 1);
        tick(1'b0, 1'b1, "R5 pattern");
        chk(dlos_out === 1'b0, "R5 cleared at 4108th bit", dlos_out, 0);
        ext_mode = 1'b0;

        // R8: very long zero stretch, no wrap
        for (int i = 0; i < 5000; i++) tick(1'b0, 1'b1, "R8 zeros");
        chk(dlos_out === 1'b1, "R8 still declared", dlos_out, 1);

        // R6 / R7: sweep with state held (bit_en low)
        for (int d = 0; d < 2; d++) begin
            if (d == 1) begin
                do_reset();
                clear_by_pattern(44, "R6 prep");
            end
            bit_en = 1'b0;
            for (int v = 0; v < 16; v++) begin
                alos_in = v[0]; mute_en = v[1]; rx_bit = v[2]; rx_neg = v[3];
                @(posedge clk); #1;
                chk(los_out === (m_dl & alos_in), "R6 los and", los_out, m_dl & alos_in);
                chk(rdat_out === (rx_bit & ~(mute_en & m_dl & alos_in)), "R7 rdat", rdat_out,
                    rx_bit & ~(mute_en & m_dl & alos_in));
                chk(rneg_out === (rx_neg & ~(mute_en & m_dl & alos_in)), "R7 rneg", rneg_out,
                    rx_neg & ~(mute_en & m_dl & alos_in));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule